// File: doc/BRIEF.md
# In-Order Pipeline Progress Controller

This block decides, once per clock, how each occupied slot of a six-slot in-order pipeline moves: it advances one slot, it counts down its remaining cycles, or it stalls. The slots are, in order, prefetch, fetch, decode, execute, memory access and store commit. Each slot holds at most one instruction. For each instruction the block keeps an age tag, an operation class, a few register numbers and a countdown of the cycles it still needs in its slot. Only this control is modelled. The datapath, the register file and the caches are outside the block, which sees the caches only as hit flags.

An instruction may move only when it is ready and the slot ahead will be free. A slot will be free when it is empty or when its own occupant moves on in the same cycle, and the slot after the commit slot is always free. Readiness depends only on instructions that are older, so a younger instruction never delays an older one. Every cross-instruction interlock also points from younger to older. As a result, making any instruction progress further never makes the whole pipeline slower, and timing analysis can rely on that. A host pushes instruction descriptors in at the prefetch end. It supplies, every cycle, the latency that each slot would load on entry. It reads per-slot advance and stall flags and a retire pulse with the tag of the instruction that leaves.

Top module: `inorder_stall_ctrl`

## Requirements
- R1: After a synchronous reset every slot is empty: no advance, no stall, no retire, and `in_ready_o` is high.
- R2: `in_ready_o` is high when the prefetch slot is empty or its occupant advances in that cycle. A descriptor is taken when `in_valid_i` and `in_ready_o` are both high, and it enters prefetch at that clock edge.
- R3: In each cycle an occupied slot does exactly one of three things. It advances exactly one slot. Otherwise it decrements a nonzero count. Otherwise it stalls, which is reported on `stall_o`. On entering slot s the count loads the field `lat_i[s*CNT_W +: CNT_W]` and is never increased afterwards. Bit s of `adv_o` and `stall_o` is slot s, where 0 is prefetch, 1 fetch, 2 decode, 3 execute, 4 memory and 5 commit.
- R4: A ready instruction advances only if the next slot is empty or its occupant advances in the same cycle. The commit slot may always leave.
- R5: An instruction is ready only when its count is zero. The one exception is a store (class 2) in the memory slot, which is ready whatever its count.
- R6: An instruction in decode is not ready while an older load (class 1) whose destination equals either of its sources sits in execute, or in memory with a nonzero count.
- R7: A store in execute, or a load in execute while `dc_hit_i` is low, is not ready while an older store sits in memory, or in commit with a nonzero count.
- R8: An instruction in prefetch is not ready in two cases. The first is an older branch (class 3) in fetch, decode or execute. The second is `ic_hit_i` low while an older load or store sits in fetch through memory, or in commit with a nonzero count. Class 0 is a plain ALU operation.
- R9: The oldest instruction in the pipeline never stalls.
- R10: `retire_o` pulses in the cycle the commit occupant leaves, and `retire_tag_o` carries its tag. Tags are handed out 0, 1, 2, ... in acceptance order, modulo 2^TAG_W, from reset, so instructions retire in acceptance order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| in_valid_i | input | 1 | New descriptor offered |
| in_op_i | input | 2 | Class: 0 ALU, 1 load, 2 store, 3 branch |
| in_dst_i | input | REG_W | Destination register number |
| in_src1_i | input | REG_W | First source register number |
| in_src2_i | input | REG_W | Second source register number |
| in_ready_o | output | 1 | Prefetch slot can take a descriptor this cycle |
| ic_hit_i | input | 1 | Instruction cache hit for the prefetch occupant |
| dc_hit_i | input | 1 | Data cache hit for the execute occupant |
| lat_i | input | 6*CNT_W | Entry latency per slot, field s for slot s |
| adv_o | output | 6 | Slot occupant advances this cycle |
| stall_o | output | 6 | Slot occupant stalls this cycle |
| retire_o | output | 1 | Commit occupant leaves this cycle |
| retire_tag_o | output | TAG_W | Tag of the retiring instruction |

## Verification
The hardest situations to reach are the interlock stalls: a load missing the data cache in execute behind a store that has not yet committed, and a decode stall behind a dependent load. Each needs two instructions in adjacent slots with particular classes, register numbers, hit flags and commit latency, all at the same time. Directed pairs push exactly those sequences, each once with the blocking condition and once without. Long random runs with few register numbers and frequent misses keep the pipeline full, and a per-instruction model in the bench predicts every advance and stall.

// File: rtl/isc_pkg.sv
package isc_pkg;
   localparam int NSTG  = 6;
   localparam int S_PRE = 0;
   localparam int S_IF  = 1;
   localparam int S_ID  = 2;
   localparam int S_EX  = 3;
   localparam int S_MEM = 4;
   localparam int S_ST  = 5;

   typedef enum logic [1:0] {
      OP_ALU    = 2'd0,
      OP_LOAD   = 2'd1,
      OP_STORE  = 2'd2,
      OP_BRANCH = 2'd3
   } opcls_e;

   function automatic logic is_mem(input opcls_e op);
      return (op == OP_LOAD) || (op == OP_STORE);
   endfunction
endpackage

// File: rtl/isc_pending_scan.sv
module isc_pending_scan
   import isc_pkg::*;
#(
   parameter int REG_W = 5
) (
   input  logic [NSTG-1:1] older_valid_i,
   input  opcls_e [NSTG-1:1] older_op_i,
   input  logic cz_mem_i,
   input  logic cz_st_i,
   input  logic [REG_W-1:0] ex_dst_i,
   input  logic [REG_W-1:0] mem_dst_i,
   input  logic [REG_W-1:0] id_src1_i,
   input  logic [REG_W-1:0] id_src2_i,
   output logic br_unres_o,
   output logic mem_pend_o,
   output logic st_pend_o,
   output logic ophaz_o
);
   logic [NSTG-1:1] is_br, is_mem_op;

   for (genvar s = 1; s < NSTG; s++) begin : g_cls
      assign is_br[s]     = older_valid_i[s] && (older_op_i[s] == OP_BRANCH);
      assign is_mem_op[s] = older_valid_i[s] && is_mem(older_op_i[s]);
   end

   // a branch is resolved once it has left execute
   assign br_unres_o = |is_br[S_EX:S_IF];

   // a memory operation is pending until it sits in commit with zero count
   assign mem_pend_o = (|is_mem_op[S_MEM:S_IF]) || (is_mem_op[S_ST] && !cz_st_i);

   assign st_pend_o =
      (older_valid_i[S_MEM] && (older_op_i[S_MEM] == OP_STORE)) ||
      (older_valid_i[S_ST]  && (older_op_i[S_ST]  == OP_STORE) && !cz_st_i);

   logic ex_match, mem_match;
   assign ex_match  = (ex_dst_i  == id_src1_i) || (ex_dst_i  == id_src2_i);
   assign mem_match = (mem_dst_i == id_src1_i) || (mem_dst_i == id_src2_i);

   assign ophaz_o =
      (older_valid_i[S_EX]  && (older_op_i[S_EX]  == OP_LOAD) && ex_match) ||
      (older_valid_i[S_MEM] && (older_op_i[S_MEM] == OP_LOAD) && !cz_mem_i && mem_match);
endmodule

// File: rtl/isc_ready.sv
module isc_ready
   import isc_pkg::*;
(
   input  logic [NSTG-1:0] cz_i,
   input  opcls_e op_ex_i,
   input  opcls_e op_mem_i,
   input  logic br_unres_i,
   input  logic mem_pend_i,
   input  logic st_pend_i,
   input  logic ophaz_i,
   input  logic ic_hit_i,
   input  logic dc_hit_i,
   output logic [NSTG-1:0] ready_o
);
   logic ex_needs_order;
   assign ex_needs_order = (op_ex_i == OP_STORE) || ((op_ex_i == OP_LOAD) && !dc_hit_i);

   for (genvar s = 0; s < NSTG; s++) begin : g_rdy
      if (s == S_PRE) begin : g_pre
         assign ready_o[s] = cz_i[s] && !br_unres_i && !(mem_pend_i && !ic_hit_i);
      end else if (s == S_ID) begin : g_id
         assign ready_o[s] = cz_i[s] && !ophaz_i;
      end else if (s == S_EX) begin : g_ex
         assign ready_o[s] = cz_i[s] && !(ex_needs_order && st_pend_i);
      end else if (s == S_MEM) begin : g_mem
         assign ready_o[s] = cz_i[s] || (op_mem_i == OP_STORE);
      end else begin : g_plain
         assign ready_o[s] = cz_i[s];
      end
   end
endmodule

// File: rtl/isc_adv_chain.sv
module isc_adv_chain
   import isc_pkg::*;
(
   input  logic [NSTG-1:0] valid_i,
   input  logic [NSTG-1:0] ready_i,
   output logic [NSTG-1:0] adv_o
);
   for (genvar s = NSTG - 1; s >= 0; s--) begin : g_adv
      if (s == NSTG - 1) begin : g_tail
         assign adv_o[s] = valid_i[s] && ready_i[s];
      end else begin : g_body
         assign adv_o[s] = valid_i[s] && ready_i[s] && (!valid_i[s+1] || adv_o[s+1]);
      end
   end
endmodule

// File: rtl/inorder_stall_ctrl.sv
module inorder_stall_ctrl
   import isc_pkg::*;
#(
   parameter int TAG_W = 4,
   parameter int CNT_W = 3,
   parameter int REG_W = 5
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic in_valid_i,
   input  logic [1:0] in_op_i,
   input  logic [REG_W-1:0] in_dst_i,
   input  logic [REG_W-1:0] in_src1_i,
   input  logic [REG_W-1:0] in_src2_i,
   output logic in_ready_o,
   input  logic ic_hit_i,
   input  logic dc_hit_i,
   input  logic [NSTG*CNT_W-1:0] lat_i,
   output logic [NSTG-1:0] adv_o,
   output logic [NSTG-1:0] stall_o,
   output logic retire_o,
   output logic [TAG_W-1:0] retire_tag_o
);
   localparam int LAST    = NSTG - 1;
   localparam int DST_STG = S_MEM + 1;
   localparam int SRC_STG = S_ID + 1;

   if (TAG_W < 1 || (1 << TAG_W) <= NSTG) begin : g_bad_tag
      $error("TAG_W too small to order all in-flight instructions");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("CNT_W must be at least 1");
   end
   if (REG_W < 1) begin : g_bad_reg
      $error("REG_W must be at least 1");
   end

   logic [NSTG-1:0]              valid_q;
   opcls_e [NSTG-1:0]            op_q;
   logic [NSTG-1:0][CNT_W-1:0]   cnt_q;
   logic [NSTG-1:0][TAG_W-1:0]   tag_q;
   logic [DST_STG-1:0][REG_W-1:0] dst_q;
   logic [SRC_STG-1:0][REG_W-1:0] src1_q, src2_q;
   logic [TAG_W-1:0]             tag_ctr_q;

   logic [NSTG-1:0] cz, ready, adv, enter;
   opcls_e [NSTG-1:0]            nxt_op;
   logic [NSTG-1:0][TAG_W-1:0]   nxt_tag;
   logic [DST_STG-1:0][REG_W-1:0] nxt_dst;
   logic [SRC_STG-1:0][REG_W-1:0] nxt_src1, nxt_src2;
   logic accept;
   logic br_unres, mem_pend, st_pend, ophaz;

   assign in_ready_o = !valid_q[S_PRE] || adv[S_PRE];
   assign accept     = in_valid_i && in_ready_o;

   for (genvar s = 0; s < NSTG; s++) begin : g_src
      assign cz[s] = (cnt_q[s] == '0);
      if (s == 0) begin : g_in
         assign enter[s]   = accept;
         assign nxt_op[s]  = opcls_e'(in_op_i);
         assign nxt_tag[s] = tag_ctr_q;
      end else begin : g_shift
         assign enter[s]   = adv[s-1];
         assign nxt_op[s]  = op_q[s-1];
         assign nxt_tag[s] = tag_q[s-1];
      end
   end

   for (genvar s = 0; s < DST_STG; s++) begin : g_dsrc
      if (s == 0) begin : g_in
         assign nxt_dst[s] = in_dst_i;
      end else begin : g_shift
         assign nxt_dst[s] = dst_q[s-1];
      end
   end

   for (genvar s = 0; s < SRC_STG; s++) begin : g_ssrc
      if (s == 0) begin : g_in
         assign nxt_src1[s] = in_src1_i;
         assign nxt_src2[s] = in_src2_i;
      end else begin : g_shift
         assign nxt_src1[s] = src1_q[s-1];
         assign nxt_src2[s] = src2_q[s-1];
      end
   end

   isc_pending_scan #(.REG_W(REG_W)) u_scan (
      .older_valid_i (valid_q[LAST:1]),
      .older_op_i    (op_q[LAST:1]),
      .cz_mem_i      (cz[S_MEM]),
      .cz_st_i       (cz[S_ST]),
      .ex_dst_i      (dst_q[S_EX]),
      .mem_dst_i     (dst_q[S_MEM]),
      .id_src1_i     (src1_q[S_ID]),
      .id_src2_i     (src2_q[S_ID]),
      .br_unres_o    (br_unres),
      .mem_pend_o    (mem_pend),
      .st_pend_o     (st_pend),
      .ophaz_o       (ophaz)
   );

   isc_ready u_ready (
      .cz_i       (cz),
      .op_ex_i    (op_q[S_EX]),
      .op_mem_i   (op_q[S_MEM]),
      .br_unres_i (br_unres),
      .mem_pend_i (mem_pend),
      .st_pend_i  (st_pend),
      .ophaz_i    (ophaz),
      .ic_hit_i   (ic_hit_i),
      .dc_hit_i   (dc_hit_i),
      .ready_o    (ready)
   );

   isc_adv_chain u_chain (
      .valid_i (valid_q),
      .ready_i (ready),
      .adv_o   (adv)
   );

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         valid_q   <= '0;
         tag_ctr_q <= '0;
         cnt_q     <= '0;
         tag_q     <= '0;
         dst_q     <= '0;
         src1_q    <= '0;
         src2_q    <= '0;
         for (int s = 0; s < NSTG; s++) op_q[s] <= OP_ALU;
      end else begin
         if (accept) tag_ctr_q <= tag_ctr_q + TAG_W'(1);
         for (int s = 0; s < NSTG; s++) begin
            if (enter[s]) begin
               valid_q[s] <= 1'b1;
               op_q[s]    <= nxt_op[s];
               tag_q[s]   <= nxt_tag[s];
               cnt_q[s]   <= lat_i[s*CNT_W +: CNT_W];
            end else if (adv[s]) begin
               valid_q[s] <= 1'b0;
            end else if (valid_q[s] && !cz[s]) begin
               cnt_q[s]   <= cnt_q[s] - CNT_W'(1);
            end
         end
         for (int s = 0; s < DST_STG; s++) begin
            if (enter[s]) dst_q[s] <= nxt_dst[s];
         end
         for (int s = 0; s < SRC_STG; s++) begin
            if (enter[s]) begin
               src1_q[s] <= nxt_src1[s];
               src2_q[s] <= nxt_src2[s];
            end
         end
      end
   end

   assign adv_o        = adv;
   assign stall_o      = valid_q & ~adv & cz;
   assign retire_o     = adv[LAST];
   assign retire_tag_o = tag_q[LAST];

   // ---------------- assertions ----------------
   logic [NSTG-1:0] front;
   for (genvar s = 0; s < NSTG; s++) begin : g_front
      if (s == LAST) begin : g_tail
         assign front[s] = valid_q[s];
      end else begin : g_body
         assign front[s] = valid_q[s] && !(|valid_q[LAST:s+1]);
      end
   end

   assert_entry_tag_R2: assert property (@(posedge clk_i) disable iff (rst_i)
      accept |=> valid_q[S_PRE] && (tag_q[S_PRE] == $past(tag_ctr_q)));

   assert_store_mem_ready_R5: assert property (@(posedge clk_i) disable iff (rst_i)
      (valid_q[S_MEM] && (op_q[S_MEM] == OP_STORE) && !valid_q[S_ST]) |-> adv_o[S_MEM]);

   for (genvar s = 0; s < NSTG; s++) begin : g_chk
      assert_oldest_moves_R9: assert property (@(posedge clk_i) disable iff (rst_i)
         front[s] |-> !stall_o[s]);

      assert_countdown_R3: assert property (@(posedge clk_i) disable iff (rst_i)
         (valid_q[s] && !adv[s] && !cz[s] && !enter[s]) |=>
            (valid_q[s] && (cnt_q[s] == $past(cnt_q[s]) - CNT_W'(1))));

      if (s < LAST) begin : g_pair
         assert_one_step_R3: assert property (@(posedge clk_i) disable iff (rst_i)
            adv_o[s] |=> valid_q[s+1] && (tag_q[s+1] == $past(tag_q[s])) &&
                         (cnt_q[s+1] == $past(lat_i[(s+1)*CNT_W +: CNT_W])));

         assert_age_order_R10: assert property (@(posedge clk_i) disable iff (rst_i)
            (valid_q[s] && valid_q[s+1]) |->
               ((TAG_W'(tag_q[s] - tag_q[s+1]) != '0) &&
                (TAG_W'(tag_q[s] - tag_q[s+1]) < TAG_W'(NSTG))));
      end
   end
endmodule

// File: tb/inorder_stall_ctrl_test.sv
module inorder_stall_ctrl_test;
   import isc_pkg::*;
   localparam int CLK_PERIOD = 10;
   localparam int TAG_W = 4;
   localparam int CNT_W = 3;
   localparam int REG_W = 5;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic in_valid = 1'b0;
   logic [1:0] in_op = 2'd0;
   logic [REG_W-1:0] in_dst = '0, in_s1 = '0, in_s2 = '0;
   logic ic_hit = 1'b1, dc_hit = 1'b1;
   logic [NSTG*CNT_W-1:0] lat = '0;
   logic in_ready, retire;
   logic [NSTG-1:0] adv, stall;
   logic [TAG_W-1:0] rtag;

   inorder_stall_ctrl #(.TAG_W(TAG_W), .CNT_W(CNT_W), .REG_W(REG_W)) uut (
      .clk_i(clk), .rst_i(rst), .in_valid_i(in_valid), .in_op_i(in_op),
      .in_dst_i(in_dst), .in_src1_i(in_s1), .in_src2_i(in_s2), .in_ready_o(in_ready),
      .ic_hit_i(ic_hit), .dc_hit_i(dc_hit), .lat_i(lat), .adv_o(adv), .stall_o(stall),
      .retire_o(retire), .retire_tag_o(rtag));

   always #(CLK_PERIOD/2) clk = ~clk;

   int checks = 0, errors = 0;
   bit finished = 0;

   // per-instruction model, index 0 = oldest
   int q_stage[8], q_cnt[8], q_op[8], q_dst[8], q_s1[8], q_s2[8], q_tag[8];
   bit m_adv[8];
   int qn = 0, tag_next = 0, ret_ctr = 0;
   logic [NSTG-1:0] e_adv, e_stall, seen_stall;
   bit e_rdy, e_ret, ret_seen, do_cmp;
   int e_rtag;

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int lat_of(input int s);
      return int'(lat[s*CNT_W +: CNT_W]);
   endfunction

   function automatic logic [NSTG*CNT_W-1:0] mk_lat(input int a, b, c, d, e, f);
      logic [NSTG*CNT_W-1:0] v;
      v = {CNT_W'(f), CNT_W'(e), CNT_W'(d), CNT_W'(c), CNT_W'(b), CNT_W'(a)};
      return v;
   endfunction

   function automatic bit mem_open(input int j);
      return (q_op[j] == 1 || q_op[j] == 2) && (q_stage[j] < 5 || (q_stage[j] == 5 && q_cnt[j] != 0));
   endfunction

   task automatic model_eval();
      bit pre_busy, pre_adv, rdy, fr;
      e_adv = '0; e_stall = '0; e_ret = 0; e_rtag = 0;
      pre_busy = 0; pre_adv = 0;
      for (int k = 0; k < qn; k++) begin
         if (q_stage[k] == 4 && q_op[k] == 2) rdy = 1;
         else if (q_cnt[k] != 0) rdy = 0;
         else begin
            rdy = 1;
            for (int j = 0; j < k; j++) begin
               case (q_stage[k])
                  0: begin
                     if (q_op[j] == 3 && q_stage[j] <= 3) rdy = 0;
                     if (mem_open(j) && !ic_hit) rdy = 0;
                  end
                  2: if (q_op[j] == 1 && (q_stage[j] < 4 || (q_stage[j] == 4 && q_cnt[j] != 0)) &&
                         (q_dst[j] == q_s1[k] || q_dst[j] == q_s2[k])) rdy = 0;
                  3: if ((q_op[k] == 2 || (q_op[k] == 1 && !dc_hit)) && q_op[j] == 2 &&
                         (q_stage[j] < 5 || (q_stage[j] == 5 && q_cnt[j] != 0))) rdy = 0;
                  default: ;
               endcase
            end
         end
         fr = 1;
         if (q_stage[k] < 5)
            for (int j = 0; j < k; j++)
               if (q_stage[j] == q_stage[k] + 1) fr = m_adv[j];
         m_adv[k] = rdy && fr;
         e_adv[q_stage[k]] = m_adv[k];
         e_stall[q_stage[k]] = !m_adv[k] && q_cnt[k] == 0;
         if (q_stage[k] == 5 && m_adv[k]) begin e_ret = 1; e_rtag = q_tag[k]; end
         if (q_stage[k] == 0) begin pre_busy = 1; pre_adv = m_adv[k]; end
      end
      e_rdy = !pre_busy || pre_adv;
   endtask

   task automatic model_update();
      if (rst) begin
         qn = 0; tag_next = 0; ret_ctr = 0;
         return;
      end
      for (int k = 0; k < qn; k++) begin
         if (m_adv[k]) begin
            q_stage[k]++;
            if (q_stage[k] < 6) q_cnt[k] = lat_of(q_stage[k]);
         end else if (q_cnt[k] > 0) q_cnt[k]--;
      end
      if (qn > 0 && q_stage[0] == 6) begin
         for (int k = 1; k < qn; k++) begin
            q_stage[k-1] = q_stage[k]; q_cnt[k-1] = q_cnt[k]; q_op[k-1] = q_op[k];
            q_dst[k-1] = q_dst[k]; q_s1[k-1] = q_s1[k]; q_s2[k-1] = q_s2[k]; q_tag[k-1] = q_tag[k];
         end
         qn--;
      end
      if (in_valid && e_rdy) begin
         q_stage[qn] = 0; q_cnt[qn] = lat_of(0); q_op[qn] = int'(in_op);
         q_dst[qn] = int'(in_dst); q_s1[qn] = int'(in_s1); q_s2[qn] = int'(in_s2);
         q_tag[qn] = tag_next % (1 << TAG_W);
         tag_next++; qn++;
      end
   endtask

   task automatic compare();
      chk(adv == e_adv, "R4 R5 R6 R7 R8", "advance vector", int'(adv), int'(e_adv));
      chk(stall == e_stall, "R3", "stall vector", int'(stall), int'(e_stall));
      chk(in_ready == e_rdy, "R2", "in_ready", int'(in_ready), int'(e_rdy));
      chk(retire == e_ret, "R10", "retire pulse", int'(retire), int'(e_ret));
      if (qn > 0) chk(stall[q_stage[0]] == 1'b0, "R9", "oldest stall flag", int'(stall[q_stage[0]]), 0);
      seen_stall |= stall;
      if (retire) begin
         chk(rtag == TAG_W'(ret_ctr), "R10", "retire order tag", int'(rtag), ret_ctr % (1 << TAG_W));
         if (e_ret) chk(int'(rtag) == e_rtag, "R10", "retire tag vs model", int'(rtag), e_rtag);
         ret_ctr++; ret_seen = 1;
      end
   endtask

   task automatic step();
      @(negedge clk);
      #1;
      model_eval();
      if (do_cmp && !rst) compare();
      @(posedge clk);
      model_update();
      #1;
   endtask

   task automatic do_reset();
      rst = 1; in_valid = 0; do_cmp = 0;
      repeat (3) step();
      rst = 0;
      @(negedge clk); #1;
      chk(adv == '0 && stall == '0, "R1", "slots busy after reset", int'({adv, stall}), 0);
      chk(retire == 1'b0, "R1", "retire after reset", int'(retire), 0);
      chk(in_ready == 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);
      @(posedge clk); #1;
      do_cmp = 1;
   endtask

   task automatic drain();
      in_valid = 0;
      for (int i = 0; i < 300 && qn > 0; i++) step();
   endtask

   task automatic latency_case(input int op, input logic [NSTG*CNT_W-1:0] lv, input int exp_n, input string req);
      int n;
      ic_hit = 1; dc_hit = 1; lat = '0;
      drain();
      lat = lv; in_op = 2'(op); in_dst = 5'd9; in_s1 = 5'd10; in_s2 = 5'd11; in_valid = 1;
      step();
      in_valid = 0; ret_seen = 0; n = 0;
      while (!ret_seen && n < 100) begin step(); n++; end
      chk(n == exp_n, req, "accept-to-retire cycles", n, exp_n);
   endtask

   task automatic pair_case(input int op_a, input int op_b, input int s1_b, input logic [NSTG*CNT_W-1:0] lv,
                            input bit ich, input bit dch, input int stg, input bit exp_seen, input string req);
      ic_hit = 1; dc_hit = 1; lat = '0;
      drain();
      lat = lv; ic_hit = ich; dc_hit = dch; seen_stall = '0;
      in_op = 2'(op_a); in_dst = 5'd3; in_s1 = 5'd0; in_s2 = 5'd7; in_valid = 1;
      step();
      in_op = 2'(op_b); in_dst = 5'd5; in_s1 = 5'(s1_b); in_s2 = 5'd7;
      step();
      drain();
      chk(seen_stall[stg] == exp_seen, req, $sformatf("stall seen in slot %0d", stg),
          int'(seen_stall[stg]), int'(exp_seen));
   endtask

   task automatic random_run(input int cycles);
      for (int i = 0; i < cycles; i++) begin
         in_valid = ($urandom % 4) != 0;
         in_op = 2'($urandom % 4);
         in_dst = 5'($urandom % 4);
         in_s1 = 5'($urandom % 4);
         in_s2 = 5'($urandom % 4);
         ic_hit = ($urandom % 3) != 0;
         dc_hit = ($urandom % 3) != 0;
         for (int s = 0; s < NSTG; s++) lat[s*CNT_W +: CNT_W] = CNT_W'(($urandom % 5 == 0) ? 3 : $urandom % 2);
         step();
      end
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog: run did not complete, actual 1 expected 0");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd2024));
      do_reset();
      // R3/R5: single instruction timing = sum over slots of (latency + 1)
      latency_case(0, mk_lat(2, 2, 2, 2, 2, 2), 18, "R3");
      latency_case(2, mk_lat(2, 2, 2, 2, 2, 2), 16, "R5");
      latency_case(1, mk_lat(0, 1, 2, 3, 0, 1), 13, "R3");
      // R6: dependent vs independent after a load
      pair_case(1, 0, 3, mk_lat(0, 0, 0, 0, 0, 0), 1, 1, S_ID, 1, "R6");
      pair_case(1, 0, 4, mk_lat(0, 0, 0, 0, 0, 0), 1, 1, S_ID, 0, "R6");
      // R7: load after a store, miss vs hit
      pair_case(2, 1, 0, mk_lat(0, 0, 0, 0, 0, 3), 1, 0, S_EX, 1, "R7");
      pair_case(2, 1, 0, mk_lat(0, 0, 0, 0, 0, 3), 1, 1, S_EX, 0, "R7");
      // R8: prefetch blocked by branch or by memory op on icache miss
      pair_case(3, 0, 0, mk_lat(0, 0, 0, 0, 0, 0), 1, 1, S_PRE, 1, "R8");
      pair_case(0, 0, 0, mk_lat(0, 0, 0, 0, 0, 0), 1, 1, S_PRE, 0, "R8");
      pair_case(1, 0, 0, mk_lat(0, 0, 0, 0, 0, 0), 0, 1, S_PRE, 1, "R8");
      pair_case(1, 0, 0, mk_lat(0, 0, 0, 0, 0, 0), 1, 1, S_PRE, 0, "R8");
      // random traffic, a reset in the middle, more traffic
      random_run(3000);
      do_reset();
      random_run(3000);
      ic_hit = 1; dc_hit = 1; lat = '0;
      drain();
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule